// File: doc/BRIEF.md
# Synchronized Stereo Capture to Byte Stream

This block fires the exposure trigger of two image sensors in the same clock cycle and then collects the frame that each sensor returns. Each sensor presents 10-bit pixels with frame-valid and line-valid qualifiers and a pixel strobe. The strobe marks the sensor's pixel clock edge, sampled in the block's clock domain. The block halves the image in both directions by keeping the even columns of the even lines. It truncates every kept pixel to its eight most significant bits and holds each eye's bytes in a FIFO of its own.

A streaming state machine drains the two FIFOs into a single byte-wide write port toward a USB bridge. It emits whole lines in strict alternation, left eye first. Each line starts with a header byte that names the eye and flags the first line of the frame. The bridge's full flag throttles every write. If either FIFO would be pushed while full, the frame is abandoned and both FIFOs are emptied. A sticky bad-frame flag is raised, and the next accepted capture request starts a clean frame.

The state machine has seven states. `ST_IDLE` waits for a request. `ST_WAIT_L` and `ST_WAIT_R` wait until a full decimated line is buffered for that eye. `ST_HDR_L` and `ST_HDR_R` send the header byte. `ST_DATA_L` and `ST_DATA_R` send the line's pixel bytes. Its transitions are:
- request accepted: `ST_IDLE` to `ST_WAIT_L`
- line ready: `ST_WAIT_L` to `ST_HDR_L` and `ST_WAIT_R` to `ST_HDR_R`
- header sent: `ST_HDR_L` to `ST_DATA_L` and `ST_HDR_R` to `ST_DATA_R`
- left line sent: `ST_DATA_L` to `ST_WAIT_R`
- right line sent: `ST_DATA_R` to `ST_WAIT_L`, or to `ST_IDLE` after the last line pair
- abort on overflow: any busy state to `ST_IDLE`

Each eye's capture unit has its own three-state machine. `CAP_OFF` is disarmed. `CAP_WAIT` waits for frame-valid to rise. `CAP_RUN` collects pixels until frame-valid falls.

Top module: `stereo_capture_streamer`

## Requirements
- R1: A capture request seen while idle makes `trig_left` and `trig_right` high together for exactly one cycle, in the cycle after the request is sampled.
- R2: A capture request that arrives while a stereo frame is being captured or streamed is ignored: no trigger pulse, and the frame's byte stream is unchanged.
- R3: Within a frame, only pixels at even column index and even line index are kept. Indices count from 0 at the first pixel of a line and at the first line after frame-valid rises. A line ends where line-valid falls.
- R4: Each kept pixel is sent as its upper 8 bits, pixel[9:2].
- R5: Lines go out as left, right, left, right and so on. Each line is one header byte followed by SRC_W/2 pixel bytes. The header is 0x80 | (first_line << 1) | eye, with eye 0 for left and 1 for right, so the headers are 0x82 and 0x83 for line 0 and 0x80 and 0x81 for later lines.
- R6: `usb_sof` is high only with the first header byte (0x82) of a frame. `usb_eof` is high only with the last pixel byte of the last right-eye line.
- R7: `usb_wr` is never high while `usb_full` is high, and backpressure loses or reorders no byte.
- R8: A push into a full FIFO sets `frame_bad`. It also stops the frame at once: nothing more is written for that frame, and both FIFOs are emptied.
- R9: `frame_bad` stays set until the next accepted capture request and is cleared in the same cycle that request's trigger pulse appears.
- R10: After reset, the triggers, `usb_wr`, `usb_sof`, `usb_eof` and `frame_bad` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_req | input | 1 | Capture request from the control register |
| trig_left | output | 1 | Exposure trigger pulse, left sensor |
| trig_right | output | 1 | Exposure trigger pulse, right sensor |
| l_pix_stb | input | 1 | Left pixel clock edge, one-cycle strobe |
| l_fv | input | 1 | Left frame valid |
| l_lv | input | 1 | Left line valid |
| l_pix | input | PIX_W | Left pixel data |
| r_pix_stb | input | 1 | Right pixel clock edge, one-cycle strobe |
| r_fv | input | 1 | Right frame valid |
| r_lv | input | 1 | Right line valid |
| r_pix | input | PIX_W | Right pixel data |
| usb_full | input | 1 | Bridge cannot take a byte this cycle |
| usb_data | output | 8 | Byte toward the bridge |
| usb_wr | output | 1 | Write strobe for `usb_data` |
| usb_sof | output | 1 | Marks the first byte of a frame |
| usb_eof | output | 1 | Marks the last byte of a frame |
| frame_bad | output | 1 | Sticky flag: last frame lost to overflow |

## Verification
The assertions check on every cycle the properties of the write port and the trigger. They cover: no write while the bridge is full, single-cycle trigger pulses, no trigger while bytes are flowing, and the start marker coinciding with the first left header. They also check that the abort silences the port and that the bad-frame flag clears only together with a trigger. Only the bench's scenarios can show the content and order of the byte stream. That covers the decimation pattern, the truncated pixel values, the header codes and the end marker position. The bench also shows the overflow-then-recovery sequence across two frames and that a request made mid-frame leaves the stream untouched.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_L,
        ST_HDR_L,
        ST_DATA_L,
        ST_WAIT_R,
        ST_HDR_R,
        ST_DATA_R
    } strm_state_t;

    typedef enum logic [1:0] {
        CAP_OFF,
        CAP_WAIT,
        CAP_RUN
    } cap_state_t;

    localparam logic [7:0] HDR_MARK = 8'h80;

    // Header: marker bit 7, first-line flag bit 1, eye bit 0 (0 = left).
    function automatic logic [7:0] line_header(input logic eye, input logic first);
        return HDR_MARK | {6'd0, first, eye};
    endfunction

endpackage

// File: rtl/stc_fifo.sv
module stc_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          ovf
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_en, rd_en;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign wr_en = push && !full;
    assign rd_en = pop && (count != '0);
    assign ovf   = push && full;
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (rd_en) rd_ptr <= ptr_next(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/stc_eye_capture.sv
module stc_eye_capture
    import stc_pkg::*;
#(
    parameter int PIX_W = 10,
    parameter int SRC_W = 640,
    parameter int SRC_H = 480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             abort,
    input  logic             pix_stb,
    input  logic             fv,
    input  logic             lv,
    input  logic [PIX_W-1:0] pix,
    output logic             push,
    output logic [7:0]       push_data
);

    localparam int XW = $clog2(SRC_W + 1);
    localparam int YW = $clog2(SRC_H + 1);

    cap_state_t    cs;
    logic          fv_q, lv_q;
    logic [XW-1:0] col;
    logic [YW-1:0] row;
    logic [PIX_W-9:0] unused_lsbs;

    assign unused_lsbs = pix[PIX_W-9:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs   <= CAP_OFF;
            fv_q <= 1'b0;
            lv_q <= 1'b0;
            col  <= '0;
            row  <= '0;
        end else begin
            if (pix_stb) begin
                fv_q <= fv;
                lv_q <= lv;
            end
            if (abort) begin
                cs <= CAP_OFF;
            end else if (arm) begin
                cs <= CAP_WAIT;
            end else begin
                unique case (cs)
                    CAP_OFF: cs <= CAP_OFF;
                    CAP_WAIT: begin
                        if (pix_stb && fv && !fv_q) begin
                            cs  <= CAP_RUN;
                            col <= '0;
                            row <= '0;
                        end
                    end
                    CAP_RUN: begin
                        if (pix_stb) begin
                            if (!fv) begin
                                cs <= CAP_OFF;
                            end else if (lv) begin
                                if (col != XW'(SRC_W)) col <= col + 1'b1;
                            end else if (lv_q) begin
                                col <= '0;
                                if (row != YW'(SRC_H)) row <= row + 1'b1;
                            end
                        end
                    end
                    default: cs <= CAP_OFF;
                endcase
            end
        end
    end

    assign push = (cs == CAP_RUN) && pix_stb && fv && lv &&
                  !col[0] && !row[0] &&
                  (col < XW'(SRC_W)) && (row < YW'(SRC_H));
    assign push_data = pix[PIX_W-1 -: 8];

endmodule

// File: rtl/stc_stream_fsm.sv
module stc_stream_fsm
    import stc_pkg::*;
#(
    parameter int OUT_W = 320,
    parameter int OUT_H = 240,
    parameter int CW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_req,
    input  logic [CW-1:0] l_count,
    input  logic [CW-1:0] r_count,
    input  logic [7:0]    l_head,
    input  logic [7:0]    r_head,
    input  logic          ovf,
    input  logic          usb_full,
    output logic          start,
    output logic          abort,
    output logic          trig,
    output logic          l_pop,
    output logic          r_pop,
    output logic [7:0]    usb_data,
    output logic          usb_wr,
    output logic          usb_sof,
    output logic          usb_eof,
    output logic          frame_bad
);

    localparam int BW = $clog2(OUT_W + 1);
    localparam int LW = $clog2(OUT_H + 1);

    strm_state_t   cs, nxt;
    logic [BW-1:0] byte_idx;
    logic [LW-1:0] line_idx;
    logic          wr_ok, first_line, last_byte, last_line;

    assign wr_ok      = !usb_full && !ovf;
    assign first_line = (line_idx == '0);
    assign last_byte  = (byte_idx == BW'(OUT_W - 1));
    assign last_line  = (line_idx == LW'(OUT_H - 1));
    assign start      = (cs == ST_IDLE) && cap_req;
    assign abort      = (cs != ST_IDLE) && ovf;

    // Next-state selection
    always_comb begin
        nxt = cs;
        unique case (cs)
            ST_IDLE:   if (cap_req) nxt = ST_WAIT_L;
            ST_WAIT_L: if (l_count >= CW'(OUT_W)) nxt = ST_HDR_L;
            ST_HDR_L:  if (wr_ok) nxt = ST_DATA_L;
            ST_DATA_L: if (wr_ok && last_byte) nxt = ST_WAIT_R;
            ST_WAIT_R: if (r_count >= CW'(OUT_W)) nxt = ST_HDR_R;
            ST_HDR_R:  if (wr_ok) nxt = ST_DATA_R;
            ST_DATA_R: if (wr_ok && last_byte) nxt = last_line ? ST_IDLE : ST_WAIT_L;
            default:   nxt = ST_IDLE;
        endcase
        if (abort) nxt = ST_IDLE;
    end

    // State register and its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs        <= ST_IDLE;
            byte_idx  <= '0;
            line_idx  <= '0;
            frame_bad <= 1'b0;
            trig      <= 1'b0;
        end else begin
            cs   <= nxt;
            trig <= start;
            if (start) frame_bad <= 1'b0;
            else if (abort) frame_bad <= 1'b1;
            if (cs == ST_HDR_L || cs == ST_HDR_R) byte_idx <= '0;
            else if ((cs == ST_DATA_L || cs == ST_DATA_R) && wr_ok) byte_idx <= byte_idx + 1'b1;
            if (start) line_idx <= '0;
            else if (cs == ST_DATA_R && wr_ok && last_byte) line_idx <= line_idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        usb_wr   = 1'b0;
        usb_data = 8'h00;
        usb_sof  = 1'b0;
        usb_eof  = 1'b0;
        l_pop    = 1'b0;
        r_pop    = 1'b0;
        unique case (cs)
            ST_HDR_L: begin
                usb_wr   = wr_ok;
                usb_data = line_header(1'b0, first_line);
                usb_sof  = wr_ok && first_line;
            end
            ST_DATA_L: begin
                usb_wr   = wr_ok;
                usb_data = l_head;
                l_pop    = wr_ok;
            end
            ST_HDR_R: begin
                usb_wr   = wr_ok;
                usb_data = line_header(1'b1, first_line);
            end
            ST_DATA_R: begin
                usb_wr   = wr_ok;
                usb_data = r_head;
                r_pop    = wr_ok;
                usb_eof  = wr_ok && last_byte && last_line;
            end
            default: begin
                usb_wr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/stereo_capture_streamer.sv
module stereo_capture_streamer #(
    parameter int PIX_W      = 10,
    parameter int SRC_W      = 640,
    parameter int SRC_H      = 480,
    parameter int FIFO_DEPTH = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_req,
    output logic             trig_left,
    output logic             trig_right,
    input  logic             l_pix_stb,
    input  logic             l_fv,
    input  logic             l_lv,
    input  logic [PIX_W-1:0] l_pix,
    input  logic             r_pix_stb,
    input  logic             r_fv,
    input  logic             r_lv,
    input  logic [PIX_W-1:0] r_pix,
    input  logic             usb_full,
    output logic [7:0]       usb_data,
    output logic             usb_wr,
    output logic             usb_sof,
    output logic             usb_eof,
    output logic             frame_bad
);

    localparam int OUT_W = SRC_W / 2;
    localparam int OUT_H = SRC_H / 2;
    localparam int CW    = $clog2(FIFO_DEPTH + 1);
    localparam int EYES  = 2;

    logic [EYES-1:0]  stb_a, fv_a, lv_a, push_a, pop_a, ovf_a, full_a;
    logic [PIX_W-1:0] pix_a  [EYES];
    logic [7:0]       pdat_a [EYES];
    logic [7:0]       head_a [EYES];
    logic [CW-1:0]    cnt_a  [EYES];
    logic             start, abort, trig, flush;

    assign stb_a    = {r_pix_stb, l_pix_stb};
    assign fv_a     = {r_fv, l_fv};
    assign lv_a     = {r_lv, l_lv};
    assign pix_a[0] = l_pix;
    assign pix_a[1] = r_pix;
    assign flush    = start || abort;

    for (genvar e = 0; e < EYES; e++) begin : g_eye
        stc_eye_capture #(
            .PIX_W(PIX_W), .SRC_W(SRC_W), .SRC_H(SRC_H)
        ) cap_i (
            .clk(clk), .rst_n(rst_n), .arm(start), .abort(abort),
            .pix_stb(stb_a[e]), .fv(fv_a[e]), .lv(lv_a[e]), .pix(pix_a[e]),
            .push(push_a[e]), .push_data(pdat_a[e])
        );

        stc_fifo #(
            .DW(8), .DEPTH(FIFO_DEPTH)
        ) fifo_i (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .push(push_a[e]), .din(pdat_a[e]), .pop(pop_a[e]),
            .dout(head_a[e]), .count(cnt_a[e]), .full(full_a[e]), .ovf(ovf_a[e])
        );
    end

    logic unused_full;
    assign unused_full = |full_a;

    stc_stream_fsm #(
        .OUT_W(OUT_W), .OUT_H(OUT_H), .CW(CW)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .cap_req(cap_req),
        .l_count(cnt_a[0]), .r_count(cnt_a[1]),
        .l_head(head_a[0]), .r_head(head_a[1]),
        .ovf(|ovf_a), .usb_full(usb_full),
        .start(start), .abort(abort), .trig(trig),
        .l_pop(pop_a[0]), .r_pop(pop_a[1]),
        .usb_data(usb_data), .usb_wr(usb_wr),
        .usb_sof(usb_sof), .usb_eof(usb_eof), .frame_bad(frame_bad)
    );

    assign trig_left  = trig;
    assign trig_right = trig;

endmodule

// File: rtl/stc_checker.sv
module stc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_left,
    input logic       usb_full,
    input logic [7:0] usb_data,
    input logic       usb_wr,
    input logic       usb_sof,
    input logic       usb_eof,
    input logic       frame_bad
);

    p_trig_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trig_left |=> !trig_left);

    p_no_trig_while_writing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        usb_wr |-> !trig_left);

    p_sof_first_header_r6: assert property (@(posedge clk) disable iff (!rst_n)
        usb_sof |-> (usb_wr && usb_data == 8'h82));

    p_eof_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        usb_eof |-> usb_wr);

    p_no_wr_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        usb_full |-> !usb_wr);

    p_abort_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_bad) |-> !usb_wr);

    p_bad_clears_with_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_bad) |-> trig_left);

endmodule

bind stereo_capture_streamer stc_checker chk_i (
    .clk(clk), .rst_n(rst_n), .trig_left(trig_left), .usb_full(usb_full),
    .usb_data(usb_data), .usb_wr(usb_wr), .usb_sof(usb_sof),
    .usb_eof(usb_eof), .frame_bad(frame_bad)
);

// File: tb/stereo_capture_streamer_tb_top.sv
module stereo_capture_streamer_tb_top;

    localparam int PIX_W = 10;
    localparam int SRC_W = 16;
    localparam int SRC_H = 8;
    localparam int DEPTH = 16;
    localparam int OUT_W = SRC_W / 2;
    localparam int OUT_H = SRC_H / 2;
    localparam int FRAME_BYTES = 2 * OUT_H * (OUT_W + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_req = 1'b0;
    logic trig_left, trig_right;
    logic l_pix_stb = 1'b0, l_fv = 1'b0, l_lv = 1'b0;
    logic r_pix_stb = 1'b0, r_fv = 1'b0, r_lv = 1'b0;
    logic [PIX_W-1:0] l_pix = '0, r_pix = '0;
    logic usb_full = 1'b0;
    logic [7:0] usb_data;
    logic usb_wr, usb_sof, usb_eof, frame_bad;

    int checks = 0;
    int fails = 0;
    int full_mode = 0;
    int n_cap = 0;
    int n_trig = 0;
    int pair_err = 0;
    int wr_full_err = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [7:0] cap_d [256];
    bit cap_sof [256];
    bit cap_eof [256];

    always #5 clk = ~clk;

    stereo_capture_streamer #(
        .PIX_W(PIX_W), .SRC_W(SRC_W), .SRC_H(SRC_H), .FIFO_DEPTH(DEPTH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cap_req(cap_req),
        .trig_left(trig_left), .trig_right(trig_right),
        .l_pix_stb(l_pix_stb), .l_fv(l_fv), .l_lv(l_lv), .l_pix(l_pix),
        .r_pix_stb(r_pix_stb), .r_fv(r_fv), .r_lv(r_lv), .r_pix(r_pix),
        .usb_full(usb_full), .usb_data(usb_data), .usb_wr(usb_wr),
        .usb_sof(usb_sof), .usb_eof(usb_eof), .frame_bad(frame_bad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [9:0] pixv(input int eye, input int x, input int y, input int unsigned salt);
        return 10'((x * 37 + y * 113 + eye * 401 + int'(salt)) & 1023);
    endfunction

    function automatic logic [7:0] exp_byte(input int idx, input int unsigned salt);
        int line_len = OUT_W + 1;
        int seg  = idx / line_len;
        int pos  = idx % line_len;
        int pair = seg / 2;
        int eye  = seg % 2;
        logic [9:0] p;
        if (pos == 0) return 8'h80 | 8'((pair == 0) ? 2 : 0) | 8'(eye);
        p = pixv(eye, 2 * (pos - 1), 2 * pair, salt);
        return p[9:2];
    endfunction

    // Bridge backpressure
    always @(posedge clk) begin
        #1;
        case (full_mode)
            1: usb_full = ($urandom % 4) == 0;
            2: usb_full = 1'b1;
            default: usb_full = 1'b0;
        endcase
    end

    // Output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (usb_wr && usb_full) wr_full_err++;
            if (usb_wr && n_cap < 256) begin
                cap_d[n_cap]   = usb_data;
                cap_sof[n_cap] = usb_sof;
                cap_eof[n_cap] = usb_eof;
                n_cap++;
            end
            if (trig_left) n_trig++;
            if (trig_left !== trig_right) pair_err++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            report();
        end
    end

    task automatic tick(input bit fv, input bit lv, input int x, input int y, input int unsigned salt);
        @(posedge clk); #1;
        l_pix_stb = 1'b1; r_pix_stb = 1'b1;
        l_fv = fv; r_fv = fv; l_lv = lv; r_lv = lv;
        l_pix = pixv(0, x, y, salt);
        r_pix = pixv(1, x, y, salt);
        @(posedge clk); #1;
        l_pix_stb = 1'b0; r_pix_stb = 1'b0;
    endtask

    task automatic sensor_frame(input int unsigned salt, input bit extra_req);
        tick(1, 0, 0, 0, salt);
        tick(1, 0, 0, 0, salt);
        for (int y = 0; y < SRC_H; y++) begin
            for (int x = 0; x < SRC_W; x++) begin
                if (extra_req && y == 3 && x == 0) cap_req = 1'b1;
                tick(1, 1, x, y, salt);
                cap_req = 1'b0;
            end
            for (int b = 0; b < 4; b++) tick(1, 0, 0, y, salt);
        end
        tick(0, 0, 0, 0, salt);
        tick(0, 0, 0, 0, salt);
    endtask

    // R1 and R9: trigger timing and flag clearing
    task automatic trigger();
        @(posedge clk); #1;
        cap_req = 1'b1;
        @(posedge clk); #1;
        cap_req = 1'b0;
        @(negedge clk);
        chk(trig_left && trig_right, "R1 trigger pair", {trig_left, trig_right}, 3);
        chk(frame_bad == 1'b0, "R9 bad flag cleared at trigger", frame_bad, 0);
        @(negedge clk);
        chk(!trig_left && !trig_right, "R1 single pulse", {trig_left, trig_right}, 0);
    endtask

    task automatic run_frame(input int mode, input bit extra_req);
        int unsigned salt = $urandom;
        int guard = 0;
        full_mode = mode;
        n_cap = 0;
        n_trig = 0;
        trigger();
        sensor_frame(salt, extra_req);
        while (n_cap < FRAME_BYTES && guard < 2000) begin
            @(posedge clk);
            guard++;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(n_cap == FRAME_BYTES, "R5 frame byte count", n_cap, FRAME_BYTES);
        chk(n_trig == 1, "R2 one trigger per frame", n_trig, 1);
        for (int i = 0; i < FRAME_BYTES; i++) begin
            logic [7:0] e = exp_byte(i, salt);
            if (i % (OUT_W + 1) == 0)
                chk(cap_d[i] == e, "R5 header", cap_d[i], e);
            else
                chk(cap_d[i] == e, "R3 R4 pixel byte", cap_d[i], e);
            chk(cap_sof[i] == (i == 0), "R6 sof position", cap_sof[i], i == 0);
            chk(cap_eof[i] == (i == FRAME_BYTES - 1), "R6 eof position", cap_eof[i], i == FRAME_BYTES - 1);
        end
        chk(frame_bad == 1'b0, "R8 no overflow on good frame", frame_bad, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!trig_left && !trig_right, "R10 triggers low", {trig_left, trig_right}, 0);
        chk(!usb_wr && !usb_sof && !usb_eof, "R10 port idle", {usb_wr, usb_sof, usb_eof}, 0);
        chk(frame_bad == 1'b0, "R10 bad flag low", frame_bad, 0);

        run_frame(0, 1'b0);
        run_frame(1, 1'b0);
        // R2: request mid-frame is ignored
        run_frame(1, 1'b1);

        // R8: overflow with the bridge held full
        full_mode = 2;
        n_cap = 0;
        trigger();
        sensor_frame($urandom, 1'b0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(frame_bad == 1'b1, "R8 overflow sets flag", frame_bad, 1);
        chk(n_cap == 0, "R8 nothing written under full", n_cap, 0);
        full_mode = 0;
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(n_cap == 0, "R8 frame dropped after release", n_cap, 0);
        chk(frame_bad == 1'b1, "R9 flag sticky", frame_bad, 1);

        // R9 recovery at next frame start
        run_frame(1, 1'b0);
        run_frame(0, 1'b0);

        chk(wr_full_err == 0, "R7 no write while full", wr_full_err, 0);
        chk(pair_err == 0, "R1 triggers coincide", pair_err, 0);
        report();
    end

endmodule